// File: doc/BRIEF.md
# Match-Compare Timer

A 32-bit up-counting timer with a single match channel, programmed over a simple word-addressed register bus. A prescaler divides the peripheral clock, so the counter advances once every (prescale + 1) enabled cycles. Software enables, disables or clears the counter through a two-bit control register. The counter can be held at zero, together with the prescale counter, while the match value and actions are being reprogrammed.

When the counter holds the match value on a cycle where it would advance, a match takes place. Three independent action bits decide the outcome, and any combination of them is allowed. One bit raises a sticky interrupt flag. One bit loads zero instead of value + 1. One bit clears the enable bit, which freezes the counter. These bits give a free-running counter, a periodic tick (interrupt + reset) and a one-shot event (interrupt + reset + stop). The flag is cleared by writing a one to it. The `irq` output is the flag gated by the interrupt action bit.

The run control is a four-state machine whose state code is the control register: `ST_OFF` (disabled), `ST_RUN` (counting), `ST_HOLD_OFF` and `ST_HOLD_RUN` (counter held at zero, enable bit remembered). Transitions are as follows. `WRITE_CTL` moves from any state to the state named by the written bits. `MATCH_STOP` moves from `ST_RUN` to `ST_OFF` on a match with the stop action. In every other case the state stays where it is. A control write in the same cycle as `MATCH_STOP` wins.

Top module: `match_timer`

## Requirements
- R1: After reset every register reads zero, the counter is zero and `irq` is low.
- R2: Control bit 0 enables counting. Writing 0 to the control register (offset 0x04) stops the counter and keeps its value.
- R3: While control bit 1 is set, the counter and the prescale counter are zero whatever bit 0 is. The control register reads back both bits.
- R4: With prescale value P (offset 0x0C), the counter advances exactly once in every P + 1 consecutive enabled cycles.
- R5: A write to offset 0x08 loads the counter. With no match actions set, the counter wraps from 0xFFFFFFFF to 0.
- R6: A match is the counter equal to the match value (offset 0x18) on a cycle where it advances. With match-control bit 0 set (offset 0x14), a match sets flag bit 0 of offset 0x00.
- R7: With match-control bit 1 set, a match loads 0 instead of the incremented value, giving a period of match value + 1 advances.
- R8: With match-control bit 2 set, a match clears control bit 0. The counter then stays at the match value, or at 0 if bit 1 is also set, until software re-enables it.
- R9: Writing 1 to flag bit 0 clears it, and writing 0 leaves it unchanged. When a match set and a clear write fall in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when flag bit 0 and match-control bit 0 are both set. Clearing the action bit hides the interrupt but leaves the flag readable.
- R11: Count-mode register (offset 0x70, 2 bits) value 0 counts peripheral clocks. Any other value freezes the counter even when it is enabled.
- R12: Prescale, match-control (3 bits), match value and count mode read back as written. Any address that is not mapped reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe; the write takes effect at the next rising edge |
| bus_addr | input | 7 | Byte offset of the register being accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Match interrupt request, level |

## Verification
Every register in this block can be read directly. A wrong run state therefore shows up in the control readback, and a wrong prescale phase or counter value shows up at offset 0x08, both on the first sampling after the faulty edge. A missed or spurious match appears at `irq` in the cycle after the match edge. It also shows as a counter value that fails to reload to zero or fails to freeze. The bench holds the address on the counter while the bus is idle and compares it with a behavioural model on every clock. Errors in prescale or match timing are therefore caught within one advance.

// File: rtl/timer_pkg.sv
package timer_pkg;
    typedef enum logic [1:0] {
        ST_OFF      = 2'd0,
        ST_RUN      = 2'd1,
        ST_HOLD_OFF = 2'd2,
        ST_HOLD_RUN = 2'd3
    } run_state_t;

    localparam int ADDR_W = 7;
    localparam logic [ADDR_W-1:0] OFS_FLAG = 7'h00;
    localparam logic [ADDR_W-1:0] OFS_CTL  = 7'h04;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 7'h08;
    localparam logic [ADDR_W-1:0] OFS_PRE  = 7'h0C;
    localparam logic [ADDR_W-1:0] OFS_MCTL = 7'h14;
    localparam logic [ADDR_W-1:0] OFS_MVAL = 7'h18;
    localparam logic [ADDR_W-1:0] OFS_MODE = 7'h70;

    localparam int ACT_W = 3;
    localparam int ACT_INT  = 0;
    localparam int ACT_RST  = 1;
    localparam int ACT_STOP = 2;
endpackage

// File: rtl/timer_ctl_fsm.sv
module timer_ctl_fsm
    import timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic [1:0] ctl_wdata,
    input  logic       stop_req,
    output run_state_t state,
    output logic       count_en,
    output logic       hold
);
    run_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (ctl_wr) begin
            nxt = run_state_t'(ctl_wdata);
        end else begin
            unique case (state)
                ST_RUN:      if (stop_req) nxt = ST_OFF;
                ST_OFF:      nxt = ST_OFF;
                ST_HOLD_OFF: nxt = ST_HOLD_OFF;
                ST_HOLD_RUN: nxt = ST_HOLD_RUN;
            endcase
        end
    end

    always_comb begin
        count_en = 1'b0;
        hold     = 1'b0;
        unique case (state)
            ST_OFF:      ;
            ST_RUN:      count_en = 1'b1;
            ST_HOLD_OFF: hold = 1'b1;
            ST_HOLD_RUN: hold = 1'b1;
        endcase
    end
endmodule

// File: rtl/timer_regs.sv
module timer_regs
    import timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              match_evt,
    output logic [DATA_W-1:0] pre,
    output logic [ACT_W-1:0]  mctl,
    output logic [DATA_W-1:0] mval,
    output logic [MODE_W-1:0] mode,
    output logic              flag
);
    logic flag_set, flag_clr;

    assign flag_set = match_evt && mctl[ACT_INT];
    assign flag_clr = wr && (addr == OFS_FLAG) && wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre  <= '0;
            mctl <= '0;
            mval <= '0;
            mode <= '0;
        end else if (wr) begin
            unique case (addr)
                OFS_PRE:  pre  <= wdata;
                OFS_MCTL: mctl <= wdata[ACT_W-1:0];
                OFS_MVAL: mval <= wdata;
                OFS_MODE: mode <= wdata[MODE_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag <= 1'b0;
        else if (flag_set) flag <= 1'b1;
        else if (flag_clr) flag <= 1'b0;
    end
endmodule

// File: rtl/timer_counter.sv
module timer_counter #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              run,
    input  logic [DATA_W-1:0] pre,
    input  logic [DATA_W-1:0] mval,
    input  logic              act_rst,
    input  logic              act_stop,
    input  logic              cnt_wr,
    input  logic [DATA_W-1:0] cnt_wdata,
    output logic [DATA_W-1:0] cnt,
    output logic              match_evt
);
    logic [DATA_W-1:0] pc;
    logic              tick;
    logic [DATA_W-1:0] cnt_adv;

    assign tick      = run && (pc >= pre);
    assign match_evt = tick && (cnt == mval);

    always_comb begin
        cnt_adv = cnt + 1'b1;
        if (match_evt) begin
            if (act_rst)       cnt_adv = '0;
            else if (act_stop) cnt_adv = cnt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pc <= '0;
        else if (hold) pc <= '0;
        else if (run)  pc <= tick ? '0 : pc + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt <= '0;
        else if (hold)   cnt <= '0;
        else if (cnt_wr) cnt <= cnt_wdata;
        else if (tick)   cnt <= cnt_adv;
    end
endmodule

// File: rtl/match_timer.sv
module match_timer
    import timer_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [6:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    run_state_t        state;
    logic              count_en, hold, run;
    logic              ctl_wr, cnt_wr, match_evt, flag;
    logic [DATA_W-1:0] pre, mval, cnt;
    logic [ACT_W-1:0]  mctl;
    logic [MODE_W-1:0] mode;

    assign ctl_wr = bus_wr && (bus_addr == OFS_CTL);
    assign cnt_wr = bus_wr && (bus_addr == OFS_CNT);
    assign run    = count_en && (mode == '0);

    timer_ctl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(bus_wdata[1:0]),
        .stop_req(match_evt && mctl[ACT_STOP]),
        .state(state), .count_en(count_en), .hold(hold)
    );

    timer_regs #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .match_evt(match_evt), .pre(pre), .mctl(mctl), .mval(mval),
        .mode(mode), .flag(flag)
    );

    timer_counter #(.DATA_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .hold(hold), .run(run), .pre(pre), .mval(mval),
        .act_rst(mctl[ACT_RST]), .act_stop(mctl[ACT_STOP]),
        .cnt_wr(cnt_wr), .cnt_wdata(bus_wdata), .cnt(cnt), .match_evt(match_evt)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_FLAG: bus_rdata[0]          = flag;
            OFS_CTL:  bus_rdata[1:0]        = state;
            OFS_CNT:  bus_rdata             = cnt;
            OFS_PRE:  bus_rdata             = pre;
            OFS_MCTL: bus_rdata[ACT_W-1:0]  = mctl;
            OFS_MVAL: bus_rdata             = mval;
            OFS_MODE: bus_rdata[MODE_W-1:0] = mode;
            default:  bus_rdata             = '0;
        endcase
    end

    assign irq = flag && mctl[ACT_INT];
endmodule

// File: rtl/timer_checker.sv
module timer_checker
    import timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input run_state_t        state,
    input logic              hold,
    input logic [DATA_W-1:0] cnt,
    input logic              match_evt,
    input logic [ACT_W-1:0]  mctl,
    input logic              flag,
    input logic              cnt_wr,
    input logic              ctl_wr
);
    assert_hold_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && $past(hold)) |-> (cnt == '0));

    assert_flag_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && mctl[ACT_INT]) |=> flag);

    assert_match_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && mctl[ACT_RST] && !cnt_wr) |=> (cnt == '0));

    assert_match_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (match_evt && mctl[ACT_STOP] && !ctl_wr) |=> (state == ST_OFF));

    assert_off_no_match_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_RUN) |-> !match_evt);

    assert_off_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !cnt_wr) |=> $stable(cnt));
endmodule

bind match_timer timer_checker #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .hold(hold), .cnt(cnt),
    .match_evt(match_evt), .mctl(mctl), .flag(flag), .cnt_wr(cnt_wr), .ctl_wr(ctl_wr)
);

// File: tb/test_match_timer.sv
module test_match_timer;
    localparam logic [6:0] A_FLAG = 7'h00, A_CTL = 7'h04, A_CNT = 7'h08, A_PRE = 7'h0C,
                           A_MCTL = 7'h14, A_MVAL = 7'h18, A_MODE = 7'h70;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = A_CNT;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string phase = "R1";

    always #5 clk = ~clk;

    match_timer i_match_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // behavioural reference model
    int unsigned m_cnt, m_pc, m_pre, m_mval;
    bit [2:0] m_mctl;
    bit [1:0] m_ctl, m_mode;
    bit       m_flag;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt <= 0; m_pc <= 0; m_pre <= 0; m_mval <= 0;
            m_mctl <= 0; m_ctl <= 0; m_mode <= 0; m_flag <= 0;
        end else begin
            bit running, held, adv, hit;
            int unsigned n_cnt, n_pc;
            bit [1:0] n_ctl;
            bit n_flag;
            held    = m_ctl[1];
            running = (m_ctl == 2'b01) && (m_mode == 0);
            adv     = running && (m_pc >= m_pre);
            hit     = adv && (m_cnt == m_mval);
            n_cnt = m_cnt; n_pc = m_pc; n_ctl = m_ctl; n_flag = m_flag;
            if (running) n_pc = adv ? 0 : m_pc + 1;
            if (adv) begin
                if (!hit) n_cnt = m_cnt + 1;
                else if (m_mctl[1]) n_cnt = 0;
                else if (!m_mctl[2]) n_cnt = m_cnt + 1;
            end
            if (hit && m_mctl[2]) n_ctl = 2'b00;
            if (bus_wr && bus_addr == A_FLAG && bus_wdata[0]) n_flag = 0;
            if (hit && m_mctl[0]) n_flag = 1;
            if (bus_wr) begin
                case (bus_addr)
                    A_CTL:  n_ctl = bus_wdata[1:0];
                    A_CNT:  n_cnt = bus_wdata;
                    A_PRE:  m_pre <= bus_wdata;
                    A_MCTL: m_mctl <= bus_wdata[2:0];
                    A_MVAL: m_mval <= bus_wdata;
                    A_MODE: m_mode <= bus_wdata[1:0];
                    default: ;
                endcase
            end
            if (held) begin n_cnt = 0; n_pc = 0; end
            m_cnt <= n_cnt; m_pc <= n_pc; m_ctl <= n_ctl; m_flag <= n_flag;
        end
    end

    function automatic logic [31:0] model_read(input logic [6:0] a);
        case (a)
            A_FLAG: return {31'd0, m_flag};
            A_CTL:  return {30'd0, m_ctl};
            A_CNT:  return m_cnt;
            A_PRE:  return m_pre;
            A_MCTL: return {29'd0, m_mctl};
            A_MVAL: return m_mval;
            A_MODE: return {30'd0, m_mode};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({phase, " irq"}, {31'd0, irq}, {31'd0, m_flag & m_mctl[0]});
            if (!bus_wr) check({phase, " rdata"}, bus_rdata, model_read(bus_addr));
        end
    end

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_wr = 1'b0; bus_addr = A_CNT; bus_wdata = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
    endtask

    task automatic peek(input logic [6:0] a, output logic [31:0] v);
        bus_addr = a;
        @(negedge clk); v = bus_rdata;
        @(posedge clk); #2;
        bus_addr = A_CNT;
    endtask

    task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        peek(a, v);
        check(req, v, exp);
    endtask

    initial begin
        logic [31:0] a, b, c;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;

        phase = "R1";
        rd(A_FLAG, 0, "R1 flag"); rd(A_CTL, 0, "R1 ctl"); rd(A_CNT, 0, "R1 cnt");
        rd(A_PRE, 0, "R1 pre"); rd(A_MCTL, 0, "R1 mctl"); rd(A_MVAL, 0, "R1 mval");
        check("R1 irq", {31'd0, irq}, 0);

        phase = "R12";
        wr(A_PRE, 32'h1234_5678); wr(A_MCTL, 32'hFFFF_FFFA); wr(A_MVAL, 32'hCAFE_0001);
        wr(A_MODE, 32'h7);
        rd(A_PRE, 32'h1234_5678, "R12 pre"); rd(A_MCTL, 32'h2, "R12 mctl");
        rd(A_MVAL, 32'hCAFE_0001, "R12 mval"); rd(A_MODE, 32'h3, "R12 mode");
        rd(7'h40, 0, "R12 unmapped");
        wr(A_PRE, 0); wr(A_MCTL, 0); wr(A_MVAL, 0); wr(A_MODE, 0);

        phase = "R2";
        wr(A_CTL, 1); idle(10);
        rd(A_CNT, 10, "R2 count after enable");
        wr(A_CTL, 0); peek(A_CNT, a); idle(5); peek(A_CNT, b);
        check("R2 frozen when disabled", b, a);

        phase = "R3";
        wr(A_CTL, 3); idle(2);
        rd(A_CNT, 0, "R3 held at zero"); rd(A_CTL, 3, "R3 readback");

        phase = "R4";
        wr(A_PRE, 2); wr(A_CTL, 1); idle(3);
        peek(A_CNT, a); idle(8); peek(A_CNT, b);
        check("R4 three advances in nine cycles", b - a, 3);
        wr(A_PRE, 0); wr(A_CTL, 0);

        phase = "R5";
        wr(A_CNT, 32'hFFFF_FFFD); rd(A_CNT, 32'hFFFF_FFFD, "R5 load");
        wr(A_CTL, 1); idle(4);
        rd(A_CNT, 1, "R5 wrap");

        phase = "R7";
        wr(A_CTL, 3); wr(A_MVAL, 4); wr(A_MCTL, 3); wr(A_CTL, 1); idle(10);
        rd(A_CNT, 0, "R7 reload at match");
        phase = "R6";
        rd(A_FLAG, 1, "R6 flag set");
        check("R6 irq", {31'd0, irq}, 1);
        wr(A_CTL, 0);

        phase = "R10";
        wr(A_MCTL, 2);
        check("R10 irq masked", {31'd0, irq}, 0);
        rd(A_FLAG, 1, "R10 flag kept");

        phase = "R9";
        wr(A_FLAG, 0); rd(A_FLAG, 1, "R9 write 0 no effect");
        wr(A_FLAG, 1); rd(A_FLAG, 0, "R9 write 1 clears");
        wr(A_CTL, 3); wr(A_MVAL, 2); wr(A_MCTL, 1);
        wr(A_CTL, 1); idle(2); wr(A_FLAG, 1);
        rd(A_FLAG, 1, "R9 set wins over clear");
        wr(A_CTL, 0); wr(A_FLAG, 1);

        phase = "R8";
        wr(A_CTL, 3); wr(A_MVAL, 3); wr(A_MCTL, 4); wr(A_CTL, 1); idle(10);
        rd(A_CTL, 0, "R8 enable cleared"); rd(A_CNT, 3, "R8 stays at match value");
        wr(A_MCTL, 6); wr(A_CTL, 3); wr(A_CTL, 1); idle(10);
        rd(A_CTL, 0, "R8 one-shot stopped"); rd(A_CNT, 0, "R8 one-shot at zero");

        phase = "R11";
        wr(A_MCTL, 0); wr(A_MODE, 1); wr(A_CTL, 1);
        peek(A_CNT, a); idle(5); peek(A_CNT, b);
        check("R11 nonzero mode freezes", b, a);
        rd(A_MODE, 1, "R11 mode readback");
        wr(A_MODE, 0); idle(3); peek(A_CNT, c);
        check("R11 mode 0 counts", c, b + 3);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule